// File: doc/BRIEF.md
# Triangular Wavefront Index Scheduler

This block generates the visiting order for the cells of a square n-by-n matrix in a triangular solve. It walks the matrix one diagonal at a time, starting at the bottom-left cell. A cell computed on one diagonal is therefore not read again until a configurable read-after-write latency has elapsed. When a diagonal is too short to cover that latency, the scheduler pads it with dummy positions that lie outside the matrix. The downstream datapath sees these as cycles with nothing to do.

After a start request, the block emits one (row, column, valid) triple per clock for a fixed number of cycles. The matrix size and the latency set that count at elaboration. A one-cycle done pulse follows the last triple, and the block then returns to idle. The block holds no matrix storage and does no arithmetic. A datapath uses the triples as addresses and as a write enable.

Top module: `wf_sched`

## Requirements
- R1: While reset is high and after it is released, the block is idle: `step_vld`, `cell_ok` and `done` are low, and `step_row` and `step_col` read zero.
- R2: A `start` sampled high while idle begins a run. The first triple appears in the cycle after that edge, with row N-1 and column 0.
- R3: A run emits exactly T triples in consecutive cycles, one per cycle. T = N(N+1)/2 + P + W, where P = (N-1)(L-N) + (N-2)(N-1)/2 when L > N and (L-2)(L-1)/2 otherwise, and W = (N-2)(N-1)/2 + max(N-1, L-1). This gives T = 19 for N=4, L=4 and T = 27 for N=4, L=6.
- R4: Within a diagonal, each new triple has both row and column one higher than the previous one. This continues until the row equals the current row limit.
- R5: After the row limit is reached, let d be the number of diagonals already completed before the one just finished, and let s = d + 3 - N. The next diagonal begins at column max(s, 0) and row max(-s, 0). The first diagonal opens at row N-2, column 0.
- R6: The row limit starts at N-1 and changes only at diagonal boundaries. It takes the value computed one boundary earlier. Near the end of the walk it is raised to at least L-1, so later diagonals run past the matrix edge as dummy positions.
- R7: `cell_ok` is high exactly on strobed cycles whose row and column are both below N. It is low on padding positions and whenever `step_vld` is low.
- R8: `done` is high for exactly one cycle, immediately after the last triple, with `step_vld` low. The block is idle in the cycle that follows.
- R9: `start` has no effect while a run is in progress or during the done cycle.
- R10: Runs started back to back produce identical sequences.
- R11: A reset asserted during a run stops it. The next cycle shows the idle state of R1, and a later start yields the full sequence from its beginning.
- R12: N must be at least 4. Smaller sizes are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, honoured only while idle |
| step_vld | output | 1 | A triple is presented this cycle |
| step_row | output | IDX_W | Row index of the current position |
| step_col | output | IDX_W | Column index of the current position |
| cell_ok | output | 1 | Current position lies inside the matrix |
| done | output | 1 | One-cycle pulse after the final triple |

## Verification
The bench drives two latency settings, one equal to N and one above it, so both formulas for the row limit are exercised. Every emitted position is compared against a hand-derived table for each setting. A wrong diagonal start or a missing clamp would show up as a shifted row or column at the first position after a boundary. A wrong limit rule would make the padding runs the wrong length and move every later index. Further directed tests pulse `start` in the middle of a run and during the done cycle. A scheduler that restarts or extends its run would then produce a longer strobe train or a second run. A reset in the middle of a run must leave the outputs idle, and the run that follows must begin again from the first position.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    // Cells on and below the main diagonal.
    function automatic int useful_iters(input int n);
        return n * (n + 1) / 2;
    endfunction

    // Padding needed so each diagonal covers the read-after-write latency.
    function automatic int pad_iters(input int n, input int l);
        if (l > n)
            return (n - 1) * (l - n) + (n - 2) * (n - 1) / 2;
        else
            return (l - 2) * (l - 1) / 2;
    endfunction

    // Warm-up iterations at the head of the walk.
    function automatic int warmup_iters(input int n, input int l);
        return (n - 2) * (n - 1) / 2 + ((n - 1 < l - 1) ? (l - 1) : (n - 1));
    endfunction

    function automatic int total_iters(input int n, input int l);
        return useful_iters(n) + pad_iters(n, l) + warmup_iters(n, l);
    endfunction

    // Index width: covers positions past the edge during padding.
    function automatic int idx_bits(input int n, input int l);
        return $clog2(2 * (n + l) + 8) + 1;
    endfunction

    function automatic int cnt_bits(input int total);
        return $clog2(total + 1);
    endfunction

endpackage

// File: rtl/wfs_iter_counter.sv
module wfs_iter_counter #(
    parameter int TOTAL = 19,
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(TOTAL - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_V);

endmodule

// File: rtl/wfs_phase_ctrl.sv
module wfs_phase_ctrl
    import wfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic last,
    output logic load,
    output logic running,
    output logic finished
);
    phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        load    = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_RUN;
                    load    = 1'b1;
                end
            end
            PH_RUN:  if (last) phase_d = PH_DONE;
            PH_DONE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    assign running  = (phase_q == PH_RUN);
    assign finished = (phase_q == PH_DONE);

endmodule

// File: rtl/wfs_diag_walker.sv
module wfs_diag_walker #(
    parameter int N       = 4,
    parameter int RAW_LAT = 4,
    parameter int SW      = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 adv,
    output logic signed [SW-1:0] row_o,
    output logic signed [SW-1:0] col_o
);
    localparam logic signed [SW-1:0] C_ZERO = '0;
    localparam logic signed [SW-1:0] C_ONE  = SW'(1);
    localparam logic signed [SW-1:0] C_TWO  = SW'(2);
    localparam logic signed [SW-1:0] C_N    = SW'(N);
    localparam logic signed [SW-1:0] C_NM1  = SW'(N - 1);
    localparam logic signed [SW-1:0] C_NM2  = SW'(N - 2);
    localparam logic signed [SW-1:0] C_LM1  = SW'(RAW_LAT - 1);
    localparam logic signed [SW-1:0] C_3MN  = SW'(3 - N);

    function automatic logic signed [SW-1:0] smax(
        input logic signed [SW-1:0] a,
        input logic signed [SW-1:0] b
    );
        return (a > b) ? a : b;
    endfunction

    // Walk state: current position, active/queued row limit, queued
    // diagonal size, diagonal counter and queued diagonal start.
    logic signed [SW-1:0] row_q, col_q;
    logic signed [SW-1:0] lim_q, nlim_q;
    logic signed [SW-1:0] nsize_q;
    logic signed [SW-1:0] diag_q;
    logic signed [SW-1:0] srow_q, scol_q;

    logic                 hit;
    logic signed [SW-1:0] sdiff;
    logic signed [SW-1:0] nsize_nx;
    logic signed [SW-1:0] nlim_calc;

    always_comb begin
        hit      = (row_q == lim_q);
        sdiff    = diag_q + C_3MN;
        nsize_nx = (diag_q >= C_NM2) ? (nsize_q - C_ONE) : (nsize_q + C_ONE);
    end

    // The limit rule depends on whether the latency exceeds the size.
    generate
        if (RAW_LAT > N) begin : g_long_lat
            assign nlim_calc = ((diag_q + C_TWO) >= C_NM2) ? smax(nsize_q, C_LM1) : C_NM1;
        end else begin : g_short_lat
            assign nlim_calc = ((diag_q + C_TWO) >= C_N) ? smax(nsize_q - C_TWO, C_LM1) : C_NM1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q   <= C_ZERO;
            col_q   <= C_ZERO;
            lim_q   <= C_ZERO;
            nlim_q  <= C_ZERO;
            nsize_q <= C_ZERO;
            diag_q  <= C_ZERO;
            srow_q  <= C_ZERO;
            scol_q  <= C_ZERO;
        end else if (load) begin
            row_q   <= C_NM1;
            col_q   <= C_ZERO;
            lim_q   <= C_NM1;
            nlim_q  <= C_NM1;
            nsize_q <= C_TWO;
            diag_q  <= C_ZERO;
            srow_q  <= C_NM2;
            scol_q  <= C_ZERO;
        end else if (adv) begin
            if (hit) begin
                lim_q   <= nlim_q;
                nlim_q  <= nlim_calc;
                nsize_q <= nsize_nx;
                row_q   <= srow_q;
                col_q   <= scol_q;
                scol_q  <= sdiff[SW-1] ? C_ZERO : sdiff;
                srow_q  <= sdiff[SW-1] ? (C_ZERO - sdiff) : C_ZERO;
                diag_q  <= diag_q + C_ONE;
            end else begin
                row_q <= row_q + C_ONE;
                col_q <= col_q + C_ONE;
            end
        end
    end

    assign row_o = row_q;
    assign col_o = col_q;

endmodule

// File: rtl/wf_sched.sv
module wf_sched #(
    parameter int N       = 4,
    parameter int RAW_LAT = 4,
    localparam int IDX_W  = wfs_pkg::idx_bits(N, RAW_LAT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             step_vld,
    output logic [IDX_W-1:0] step_row,
    output logic [IDX_W-1:0] step_col,
    output logic             cell_ok,
    output logic             done
);
    localparam int TOTAL = wfs_pkg::total_iters(N, RAW_LAT);
    localparam int CNT_W = wfs_pkg::cnt_bits(TOTAL);
    localparam int SW    = IDX_W + 1;
    localparam logic signed [SW-1:0] C_N = SW'(N);

    // R12: size check at elaboration
    generate
        if (N < 4) begin : g_size_check
            $error("wf_sched: N must be at least 4");
        end
    endgenerate

    logic                 load, running, finished, last;
    logic signed [SW-1:0] row_s, col_s;

    wfs_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .last     (last),
        .load     (load),
        .running  (running),
        .finished (finished)
    );

    wfs_iter_counter #(
        .TOTAL (TOTAL),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .step  (running),
        .last  (last)
    );

    wfs_diag_walker #(
        .N       (N),
        .RAW_LAT (RAW_LAT),
        .SW      (SW)
    ) u_walk (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .adv   (running),
        .row_o (row_s),
        .col_o (col_s)
    );

    assign step_vld = running;
    assign step_row = running ? row_s[IDX_W-1:0] : '0;
    assign step_col = running ? col_s[IDX_W-1:0] : '0;
    assign cell_ok  = running && !row_s[SW-1] && !col_s[SW-1] && (row_s < C_N) && (col_s < C_N);
    assign done     = finished;

endmodule

// File: rtl/wf_sched_checker.sv
module wf_sched_checker #(
    parameter int N       = 4,
    parameter int RAW_LAT = 4,
    parameter int IDX_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             step_vld,
    input logic [IDX_W-1:0] step_row,
    input logic [IDX_W-1:0] step_col,
    input logic             cell_ok,
    input logic             done
);
    localparam int TOTAL = wfs_pkg::total_iters(N, RAW_LAT);

    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || done)
            run_len <= '0;
        else if (step_vld)
            run_len <= run_len + 32'd1;
    end

    assert_first_cell_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(step_vld) |-> (step_row == IDX_W'(N - 1) && step_col == '0));

    assert_run_length_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_len == 32'(TOTAL)));

    assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
        step_vld |-> (run_len < 32'(TOTAL)));

    assert_diag_step_R4: assert property (@(posedge clk) disable iff (rst)
        (step_vld && $past(step_vld) && step_row > $past(step_row)) |->
        (step_row == $past(step_row) + IDX_W'(1) && step_col == $past(step_col) + IDX_W'(1)));

    assert_diag_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (step_vld && $past(step_vld) && step_row <= $past(step_row)) |->
        (step_row == '0 || step_col == '0));

    assert_ok_gated_R7: assert property (@(posedge clk) disable iff (rst)
        cell_ok |-> step_vld);

    assert_ok_range_R7: assert property (@(posedge clk) disable iff (rst)
        (step_vld && (step_row >= IDX_W'(N) || step_col >= IDX_W'(N))) |-> !cell_ok);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !step_vld);

    assert_done_follows_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(step_vld));

endmodule

bind wf_sched wf_sched_checker #(
    .N       (N),
    .RAW_LAT (RAW_LAT),
    .IDX_W   (IDX_W)
) u_wf_chk (
    .clk      (clk),
    .rst      (rst),
    .step_vld (step_vld),
    .step_row (step_row),
    .step_col (step_col),
    .cell_ok  (cell_ok),
    .done     (done)
);

// File: tb/wf_sched_tb.sv
module wf_sched_tb;

    localparam int IW = wfs_pkg::idx_bits(4, 6);
    localparam int IA = wfs_pkg::idx_bits(4, 4);
    // Run lengths from R3: 10+3+6 and 10+9+8
    localparam int TA = 19;
    localparam int TB = 27;

    // N=4, L=4: a padding position appears on the last diagonals (R6)
    localparam int A_ROW [TA] = '{3,2,3,1,2,3,0,1,2,3,0,1,2,3,0,1,2,3,0};
    localparam int A_COL [TA] = '{0,0,1,0,1,2,0,1,2,3,1,2,3,4,2,3,4,5,3};
    localparam int A_OK  [TA] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,0,1,1,0,0,1};
    // N=4, L=6: the limit is raised to 5 from the third diagonal (R6)
    localparam int B_ROW [TB] = '{3,2,3,1,2,3,4,5,0,1,2,3,4,5,0,1,2,3,4,5,0,1,2,3,4,5,0};
    localparam int B_COL [TB] = '{0,0,1,0,1,2,3,4,0,1,2,3,4,5,1,2,3,4,5,6,2,3,4,5,6,7,3};
    localparam int B_OK  [TB] = '{1,1,1,1,1,1,0,0,1,1,1,1,0,0,1,1,1,0,0,0,1,1,0,0,0,0,1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_start = 1'b0;
    logic b_start = 1'b0;

    logic          a_vld, a_ok, a_done;
    logic [IA-1:0] a_row, a_col;
    logic          b_vld, b_ok, b_done;
    logic [IW-1:0] b_row, b_col;

    int n_checks = 0;
    int n_fail   = 0;
    bit pick     = 1'b0;

    int s_vld, s_ok, s_done, s_row, s_col;

    always #4 clk = ~clk;

    wf_sched #(.N(4), .RAW_LAT(4)) u_dut (
        .clk(clk), .rst(rst), .start(a_start),
        .step_vld(a_vld), .step_row(a_row), .step_col(a_col),
        .cell_ok(a_ok), .done(a_done)
    );

    wf_sched #(.N(4), .RAW_LAT(6)) u_dut_lat6 (
        .clk(clk), .rst(rst), .start(b_start),
        .step_vld(b_vld), .step_row(b_row), .step_col(b_col),
        .cell_ok(b_ok), .done(b_done)
    );

    always_comb begin
        if (pick) begin
            s_vld = int'(b_vld); s_ok = int'(b_ok); s_done = int'(b_done);
            s_row = int'(b_row); s_col = int'(b_col);
        end else begin
            s_vld = int'(a_vld); s_ok = int'(a_ok); s_done = int'(a_done);
            s_row = int'(a_row); s_col = int'(a_col);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_start(input logic v);
        if (pick) b_start = v;
        else      a_start = v;
    endtask

    // Walk the expected table for the selected instance. poke >= 0 pulses
    // start at that step and again during the done cycle (R9).
    task automatic run_seq(input bit which, input int poke);
        int total;
        pick  = which;
        total = which ? TB : TA;
        @(negedge clk);
        set_start(1'b1);
        @(negedge clk);
        set_start(1'b0);
        for (int i = 0; i < total; i++) begin
            int er, ec, eo;
            string rq;
            if (i > 0) @(negedge clk);
            er = which ? B_ROW[i] : A_ROW[i];
            ec = which ? B_COL[i] : A_COL[i];
            eo = which ? B_OK[i]  : A_OK[i];
            if (i == 0) rq = "R2";
            else if (er < (which ? B_ROW[i-1] : A_ROW[i-1])) rq = "R5";
            else rq = "R4";
            chk("R3", "step_vld", s_vld, 1);
            chk(rq, "row", s_row, er);
            chk(rq, "col", s_col, ec);
            chk(eo == 0 ? "R6" : "R7", "cell_ok", s_ok, eo);
            chk("R8", "done during run", s_done, 0);
            set_start((poke >= 0 && i == poke) ? 1'b1 : 1'b0);
        end
        set_start(1'b0);
        @(negedge clk);
        chk("R8", "done pulse", s_done, 1);
        chk("R3", "strobe after last", s_vld, 0);
        if (poke >= 0) set_start(1'b1);
        @(negedge clk);
        set_start(1'b0);
        chk("R8", "done width", s_done, 0);
        chk("R9", "idle after done", s_vld, 0);
        @(negedge clk);
        chk("R9", "no late restart", s_vld, 0);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: state during reset
        pick = 1'b0;
        chk("R1", "vld in reset", s_vld, 0);
        chk("R1", "done in reset", s_done, 0);
        chk("R1", "ok in reset", s_ok, 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "vld idle", s_vld, 0);
        chk("R1", "row idle", s_row, 0);
        chk("R1", "col idle", s_col, 0);

        // Table walks: both limit rules
        run_seq(1'b0, -1);
        run_seq(1'b1, -1);
        // R10: back to back repeat
        run_seq(1'b0, -1);
        // R9: start pulsed mid-run and in the done cycle
        run_seq(1'b0, 5);
        run_seq(1'b1, 11);

        // R11: reset in mid run
        pick = 1'b0;
        @(negedge clk);
        a_start = 1'b1;
        @(negedge clk);
        a_start = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11", "running before reset", s_vld, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R11", "vld after reset", s_vld, 0);
        chk("R11", "done after reset", s_done, 0);
        chk("R11", "ok after reset", s_ok, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "idle after release", s_vld, 0);
        run_seq(1'b0, -1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule